// File: doc/BRIEF.md
# Time-Multiplexed Servo Pulse Generator

This block drives a large set of hobby servos from six pins. The channels are organised as several banks of eight. A slot counter steps through eight time slots. In each slot the block places the slot number on three select lines and emits one pulse per bank. Outside the block, one 3-to-8 decoder per bank takes that bank's pulse and the shared select code, and steers the pulse to the servo of the current slot. With the default three banks there are 24 servos, and each one receives a pulse once every eight slots.

A prescaler divides the system clock down to a microsecond tick. A slot lasts a parameterised number of ticks (2500 by default), so a full frame of eight slots takes 20 ms. Every channel has its own stored pulse width, counted in ticks. The host changes a width through a single-cycle write strobe. The value is forced into the legal servo range on the way in. A stored width is copied into the bank's compare register only when a slot begins, so a write never alters a pulse that is already running.

Top module: `servo_mux_pulser`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sel_o` is 0 and every `pulse_o` bit is 0. After reset, every channel holds the neutral width, (MIN_W+MAX_W)/2 ticks.
- R2: One tick occurs every CLK_DIV clock cycles. A slot lasts exactly SLOT_TICKS ticks, so `sel_o` holds each value for SLOT_TICKS*CLK_DIV cycles.
- R3: `sel_o` carries the slot index, with bit 0 on `sel_o[0]`. It increases by one at each slot boundary and wraps from 7 to 0.
- R4: Every `pulse_o[b]` goes high in the same cycle that `sel_o` changes to a new slot. It stays high for exactly W*CLK_DIV cycles, where W is the width held for bank b at that slot, and then stays low until the next slot.
- R5: A written width below MIN_W is stored as MIN_W.
- R6: A written width above MAX_W is stored as MAX_W.
- R7: A write to a channel number of BANKS*8 or higher changes no stored width.
- R8: The compare register of each bank changes only at a slot boundary. A width written while its own slot is running leaves the current pulse unchanged and takes effect the next time that slot begins.
- R9: Channel number c maps to bank c>>3 and slot c&7. A write affects that one channel and no other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe for a channel width |
| wr_ch | input | CH_W (5) | Channel number to write |
| wr_width | input | IN_W (16) | Requested pulse width in ticks, before clamping |
| sel_o | output | 3 | Slot index for the external decoders |
| pulse_o | output | BANKS (3) | One servo pulse per bank |

## Verification
If the tick or slot counter is wrong, it shows on `sel_o` within one slot: the select code changes too early or too late, or steps to the wrong value. If a stored width or compare value is wrong, it shows as a pulse of the wrong length the next time the affected slot comes round, which is at most one frame (eight slots) later. A compare register that changes in the middle of a slot cuts short or stretches a pulse that is already running, so that pulse ends on the wrong cycle. The reference model runs alongside the design and predicts every output bit on every cycle. Because of this, any such corruption is reported in the first cycle that it reaches a pin.

// File: rtl/svp_pkg.sv
package svp_pkg;
  // Three shared select lines address eight slots per bank.
  localparam int SLOT_BITS = 3;
  localparam int SLOTS     = 1 << SLOT_BITS;
endpackage

// File: rtl/svp_prescale.sv
module svp_prescale #(
  parameter int CLK_DIV = 250
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/svp_slot_timer.sv
module svp_slot_timer
  import svp_pkg::*;
#(
  parameter int SLOT_TICKS = 2500,
  parameter int WIDTH_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  output logic [WIDTH_W-1:0]   tcnt_o,
  output logic [SLOT_BITS-1:0] slot_o,
  output logic [SLOT_BITS-1:0] next_slot_o,
  output logic                 slot_end_o
);
  localparam logic [WIDTH_W-1:0] LAST = WIDTH_W'(SLOT_TICKS - 1);

  logic [WIDTH_W-1:0]   tcnt_q;
  logic [SLOT_BITS-1:0] slot_q;

  assign next_slot_o = slot_q + 1'b1;          // wraps 7 -> 0 by width
  assign slot_end_o  = tick_i && (tcnt_q == LAST);
  assign tcnt_o      = tcnt_q;
  assign slot_o      = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt_q <= '0;
      slot_q <= '0;
    end else if (slot_end_o) begin
      tcnt_q <= '0;
      slot_q <= next_slot_o;
    end else if (tick_i) begin
      tcnt_q <= tcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/svp_wr_decode.sv
module svp_wr_decode
  import svp_pkg::*;
#(
  parameter int BANKS   = 3,
  parameter int CH_W    = 5,
  parameter int IN_W    = 16,
  parameter int WIDTH_W = 12,
  parameter int MIN_W   = 899,
  parameter int MAX_W   = 2099
) (
  input  logic                 wr_en,
  input  logic [CH_W-1:0]      wr_ch,
  input  logic [IN_W-1:0]      wr_width,
  output logic [BANKS-1:0]     bank_we_o,
  output logic [SLOT_BITS-1:0] slot_o,
  output logic [WIDTH_W-1:0]   val_o
);
  localparam logic [CH_W-1:0] CH_LIMIT = CH_W'(BANKS * SLOTS);
  localparam logic [IN_W-1:0] LO       = IN_W'(MIN_W);
  localparam logic [IN_W-1:0] HI       = IN_W'(MAX_W);

  logic            ch_ok;
  logic [CH_W-1:0] bank_idx;

  assign ch_ok    = (wr_ch < CH_LIMIT);
  assign bank_idx = wr_ch >> SLOT_BITS;
  assign slot_o   = wr_ch[SLOT_BITS-1:0];

  always_comb begin
    if (wr_width < LO)      val_o = WIDTH_W'(LO);
    else if (wr_width > HI) val_o = WIDTH_W'(HI);
    else                    val_o = WIDTH_W'(wr_width);
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_we
    assign bank_we_o[b] = wr_en && ch_ok && (bank_idx == CH_W'(b));
  end
endmodule

// File: rtl/svp_pulse_bank.sv
module svp_pulse_bank
  import svp_pkg::*;
#(
  parameter int WIDTH_W = 12,
  parameter int NEUTRAL = 1499
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  logic [SLOT_BITS-1:0] wslot_i,
  input  logic [WIDTH_W-1:0]   wval_i,
  input  logic                 load_i,
  input  logic [SLOT_BITS-1:0] next_slot_i,
  input  logic [WIDTH_W-1:0]   tcnt_i,
  output logic [WIDTH_W-1:0]   cmp_o,
  output logic                 pulse_o
);
  logic [WIDTH_W-1:0] width_q [SLOTS];
  logic [WIDTH_W-1:0] cmp_q;
  logic               pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) width_q[s] <= WIDTH_W'(NEUTRAL);
    end else if (we_i) begin
      width_q[wslot_i] <= wval_i;
    end
  end

  // The compare value is loaded only when a new slot starts.
  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= WIDTH_W'(NEUTRAL);
    else if (load_i) cmp_q <= width_q[next_slot_i];
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= (tcnt_i < cmp_q);
  end

  assign cmp_o   = cmp_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/servo_mux_pulser.sv
module servo_mux_pulser
  import svp_pkg::*;
#(
  parameter int CLK_DIV    = 250,
  parameter int SLOT_TICKS = 2500,
  parameter int BANKS      = 3,
  parameter int WIDTH_W    = 12,
  parameter int IN_W       = 16,
  parameter int MIN_W      = 899,
  parameter int MAX_W      = 2099,
  parameter int CH_W       = $clog2(BANKS * SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [CH_W-1:0]      wr_ch,
  input  logic [IN_W-1:0]      wr_width,
  output logic [SLOT_BITS-1:0] sel_o,
  output logic [BANKS-1:0]     pulse_o
);
  localparam int NEUTRAL = (MIN_W + MAX_W) / 2;

  logic                       tick;
  logic [WIDTH_W-1:0]         tcnt;
  logic [SLOT_BITS-1:0]       slot, next_slot, wslot;
  logic                       slot_end;
  logic [BANKS-1:0]           bank_we;
  logic [WIDTH_W-1:0]         wval;
  logic [BANKS*WIDTH_W-1:0]   cmp_flat;
  logic [SLOT_BITS-1:0]       sel_q;

  svp_prescale #(.CLK_DIV(CLK_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  svp_slot_timer #(.SLOT_TICKS(SLOT_TICKS), .WIDTH_W(WIDTH_W)) u_tmr (
    .clk(clk), .rst(rst), .tick_i(tick), .tcnt_o(tcnt), .slot_o(slot),
    .next_slot_o(next_slot), .slot_end_o(slot_end)
  );

  svp_wr_decode #(
    .BANKS(BANKS), .CH_W(CH_W), .IN_W(IN_W), .WIDTH_W(WIDTH_W),
    .MIN_W(MIN_W), .MAX_W(MAX_W)
  ) u_dec (
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_width(wr_width),
    .bank_we_o(bank_we), .slot_o(wslot), .val_o(wval)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    svp_pulse_bank #(.WIDTH_W(WIDTH_W), .NEUTRAL(NEUTRAL)) u_bank (
      .clk(clk), .rst(rst), .we_i(bank_we[b]), .wslot_i(wslot),
      .wval_i(wval), .load_i(slot_end), .next_slot_i(next_slot),
      .tcnt_i(tcnt), .cmp_o(cmp_flat[b*WIDTH_W +: WIDTH_W]),
      .pulse_o(pulse_o[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= slot;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/servo_mux_pulser_chk.sv
module servo_mux_pulser_chk #(
  parameter int CLK_DIV = 250,
  parameter int BANKS   = 3,
  parameter int WIDTH_W = 12,
  parameter int MIN_W   = 899,
  parameter int MAX_W   = 2099
) (
  input logic                     clk,
  input logic                     rst,
  input logic [2:0]               sel_o,
  input logic [BANKS-1:0]         pulse_o,
  input logic                     tick,
  input logic                     slot_end,
  input logic [BANKS*WIDTH_W-1:0] cmp_flat
);
  localparam int GW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [GW-1:0] gap_q;
  logic          run1_q, run2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      run1_q <= 1'b0;
      run2_q <= 1'b0;
    end else begin
      gap_q  <= tick ? '0 : gap_q + 1'b1;
      run1_q <= 1'b1;
      run2_q <= run1_q;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == GW'(CLK_DIV - 1))); // R2

  AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_o) |-> (sel_o == 3'($past(sel_o) + 3'd1))); // R3

  AST_ALL_HIGH_AT_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_o) |-> (&pulse_o)); // R4

  AST_RISE_ONLY_AT_START: assert property (@(posedge clk) disable iff (rst)
    (run2_q && ((pulse_o & ~$past(pulse_o)) != '0)) |-> !$stable(sel_o)); // R4

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !slot_end |=> $stable(cmp_flat)); // R8

  for (genvar b = 0; b < BANKS; b++) begin : g_rng
    AST_CMP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      (cmp_flat[b*WIDTH_W +: WIDTH_W] >= WIDTH_W'(MIN_W)) &&
      (cmp_flat[b*WIDTH_W +: WIDTH_W] <= WIDTH_W'(MAX_W))); // R5 R6
  end
endmodule

bind servo_mux_pulser servo_mux_pulser_chk #(
  .CLK_DIV(CLK_DIV), .BANKS(BANKS), .WIDTH_W(WIDTH_W),
  .MIN_W(MIN_W), .MAX_W(MAX_W)
) u_chk (
  .clk(clk), .rst(rst), .sel_o(sel_o), .pulse_o(pulse_o),
  .tick(tick), .slot_end(slot_end), .cmp_flat(cmp_flat)
);

// File: tb/tb_servo_mux_pulser.sv
`timescale 1ns/1ps
module tb_servo_mux_pulser;
  localparam int DIV = 2, ST = 40, NB = 3, MINW = 9, MAXW = 29;
  localparam int NEU = (MINW + MAXW) / 2;
  localparam int NCH = NB * 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [4:0] wr_ch = '0;
  logic [15:0] wr_width = '0;
  logic [2:0] sel_o;
  logic [NB-1:0] pulse_o;

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  servo_mux_pulser #(
    .CLK_DIV(DIV), .SLOT_TICKS(ST), .BANKS(NB), .WIDTH_W(12), .IN_W(16),
    .MIN_W(MINW), .MAX_W(MAXW)
  ) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_width(wr_width), .sel_o(sel_o), .pulse_o(pulse_o)
  );

  // Reference model: behavioural, updated with pre-edge values.
  int m_dv, m_tc, m_sl;
  int m_w [NCH];
  int m_cm [NB];
  int e_sel;
  int e_pul [NB];

  function automatic int clampw(int v);
    if (v < MINW) return MINW;
    if (v > MAXW) return MAXW;
    return v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_dv = 0; m_tc = 0; m_sl = 0; e_sel = 0;
      for (int i = 0; i < NCH; i++) m_w[i] = NEU;
      for (int b = 0; b < NB; b++) begin m_cm[b] = NEU; e_pul[b] = 0; end
    end else begin
      bit tk;
      e_sel = m_sl;
      for (int b = 0; b < NB; b++) e_pul[b] = (m_tc < m_cm[b]) ? 1 : 0;
      tk = (m_dv == DIV - 1);
      if (tk) begin
        if (m_tc == ST - 1) begin
          m_tc = 0;
          m_sl = (m_sl + 1) % 8;
          for (int b = 0; b < NB; b++) m_cm[b] = m_w[b * 8 + m_sl];
        end else m_tc++;
      end
      m_dv = tk ? 0 : m_dv + 1;
      if (wr_en && int'(wr_ch) < NCH) m_w[wr_ch] = clampw(int'(wr_width));
    end
  end

  // Per-cycle comparison against the model (R3 select code, R4 pulse shape).
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (int'(sel_o) != e_sel) begin
        fails++;
        $display("FAIL R3 sel_o act=%0d exp=%0d cyc=%0d", sel_o, e_sel, cyc);
      end
      for (int b = 0; b < NB; b++)
        if (int'(pulse_o[b]) != e_pul[b]) begin
          fails++;
          $display("FAIL R4 pulse_o[%0d] act=%0d exp=%0d cyc=%0d", b, pulse_o[b], e_pul[b], cyc);
        end
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int val);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 5'(ch); wr_width = 16'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Wait for the start of slot s, optionally write during it, and count
  // the cycles for which bank b stays high in that slot.
  task automatic measure(int b, int s, bit dw, int ch, int val, output int n);
    int prev;
    prev = int'(sel_o);
    @(negedge clk);
    while (!(int'(sel_o) == s && prev != s)) begin
      prev = int'(sel_o);
      @(negedge clk);
    end
    n = 0;
    if (dw) begin wr_en = 1'b1; wr_ch = 5'(ch); wr_width = 16'(val); end
    while (pulse_o[b] && int'(sel_o) == s) begin
      n++;
      @(negedge clk);
      wr_en = 1'b0;
    end
    wr_en = 1'b0;
  endtask

  task automatic slot_len(int s, output int n);
    int prev;
    prev = int'(sel_o);
    @(negedge clk);
    while (!(int'(sel_o) == s && prev != s)) begin
      prev = int'(sel_o);
      @(negedge clk);
    end
    n = 0;
    while (int'(sel_o) == s) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 sel in reset", int'(sel_o), 0);
    check("R1 pulse in reset", int'(pulse_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sel after reset", int'(sel_o), 0);

    measure(1, 3, 0, 0, 0, n); check("R1 neutral ch11", n, NEU * DIV);
    slot_len(5, n);            check("R2 slot length", n, ST * DIV);

    wr(10, 0);
    measure(1, 2, 0, 0, 0, n); check("R5 clamp low ch10", n, MINW * DIV);
    wr(21, 5000);
    measure(2, 5, 0, 0, 0, n); check("R6 clamp high ch21", n, MAXW * DIV);
    wr(3, 15);
    measure(0, 3, 0, 0, 0, n); check("R9 ch3 bank0 slot3", n, 15 * DIV);
    measure(1, 3, 0, 0, 0, n); check("R9 ch11 untouched", n, NEU * DIV);
    measure(2, 3, 0, 0, 0, n); check("R9 ch19 untouched", n, NEU * DIV);

    wr(24, 25);
    wr(31, 12);
    measure(0, 0, 0, 0, 0, n); check("R7 ch0 after ch24", n, NEU * DIV);
    measure(0, 7, 0, 0, 0, n); check("R7 ch7 after ch31", n, NEU * DIV);

    measure(1, 4, 1, 12, 25, n); check("R8 current slot keeps old", n, NEU * DIV);
    measure(1, 4, 0, 0, 0, n);   check("R8 next visit new width", n, 25 * DIV);

    // R3 wrap from 7 to 0
    while (sel_o != 3'd7) @(negedge clk);
    while (sel_o == 3'd7) @(negedge clk);
    check("R3 wrap to 0", int'(sel_o), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule